// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received frames from a byte stream into host memory. Host software builds a ring of two-word descriptors. The first word of each descriptor is a status/control word and the second is a buffer address. Software loads the address of the first descriptor through a configuration strobe and then raises a receive-enable bit. The engine reads the current descriptor over a single-word memory port that uses a request/acknowledge handshake. If software has handed the descriptor to hardware, the engine waits for the next frame start. It packs the frame bytes little-endian into words, writes them into the buffer, and then writes the status word back. That status word carries the stored length and the error flags, and its hand-over bit is cleared.

The ring is closed by a wrap bit inside the descriptor, not by a fixed ring size. A descriptor that still belongs to software stops the engine and drops receive-enable. Frames that arrive while the engine is stopped are swallowed. The next completed descriptor reports that loss in its overrun flag. Frame delineation and CRC checking happen upstream; their results arrive as sideband inputs on the last byte.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset, receive-enable reads 0 and no memory request is raised.
- R2: Once receive-enable is set, the engine reads the status word at the descriptor pointer and then the buffer address at pointer+4. Each transaction holds its request, address and direction stable until acknowledged.
- R3: If a fetched status word has bit 11 (hardware-owned) clear, the engine clears receive-enable and makes no further memory access.
- R4: Frame bytes are packed little-endian (first byte in bits 7:0) into words written at ascending addresses from the buffer address. A final partial word is written with the contiguous low byte enables 0x1, 0x3 or 0x7, and memory lanes outside them are left unchanged.
- R5: The status write-back goes to the descriptor pointer. It holds the stored byte count in bits 10:0 and bit 11 cleared, and the descriptor's wrap bit 12 is preserved.
- R6: Status bit 15 copies the CRC-bad input and bit 13 copies the alignment-error input, both sampled on the frame's last byte.
- R7: A frame longer than MAX_BUF (1540) bytes stores only its first MAX_BUF bytes and reports length MAX_BUF with bit 14 set.
- R8: After a write-back, the pointer moves to the ring base if the wrap bit was set, otherwise to pointer+8.
- R9: While receive-enable is clear, incoming bytes are accepted and discarded without any memory write. After a dropped frame start, the next status write-back has bit 16 (overrun) set.
- R10: Setting receive-enable again resumes at the current pointer, re-reading the descriptor that stopped the engine.
- R11: While waiting for a frame, bytes without the start marker are discarded.
- R12: No frame byte is accepted in a cycle with a pending memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgPtrWe | input | 1 | Load ring base and current pointer |
| cfgPtr | input | ADDR_W | Ring base address (8-byte aligned) |
| rxEnSet | input | 1 | Set receive-enable |
| rxEnable | output | 1 | Receive-enable state |
| frmValid | input | 1 | Frame byte valid |
| frmReady | output | 1 | Frame byte accepted |
| frmData | input | 8 | Frame byte |
| frmStart | input | 1 | First byte of a frame |
| frmEnd | input | 1 | Last byte of a frame |
| frmAlignErr | input | 1 | Alignment error, valid with last byte |
| frmCrcBad | input | 1 | CRC error, valid with last byte |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Byte address (word aligned) |
| memWdata | output | 32 | Write data |
| memBe | output | 4 | Byte enables |
| memRdata | input | 32 | Read data, valid with acknowledge |
| memAck | input | 1 | Transaction done |

## Verification
Some internal faults never disturb the frame data and show up only in memory. A wrong wrap or advance decision writes the next status to the wrong descriptor. A lost byte lane corrupts a buffer word while the length stays correct. For that reason the bench compares whole buffer words and status words, and it logs every read address, so a bad pointer appears as a wrong address in the very next descriptor fetch. A stale overrun or length flag is caught in the next write-back. A stuck enable shows as memory traffic, or as its absence, within a few cycles of the fetch that should have stopped the engine.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int EN_BIT   = 11;
  localparam int WRAP_BIT = 12;
  localparam int ALN_BIT  = 13;
  localparam int LONG_BIT = 14;
  localparam int CRC_BIT  = 15;
  localparam int OVR_BIT  = 16;

  typedef enum logic [1:0] {SEL_STAT, SEL_BUFP, SEL_DATA} memSel_e;

  typedef struct packed {
    logic    capStat;
    logic    capBuf;
    logic    takeByte;
    logic    newFrame;
    logic    flushWord;
    logic    finishDesc;
    logic    dropFrame;
    memSel_e sel;
  } dpCtl_t;
endpackage

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   rxEnSet,
  input  logic   frmValid,
  input  logic   frmStart,
  input  logic   memAck,
  input  logic   descOwned,
  input  logic   packFull,
  input  logic   havePartial,
  input  logic   endSeen,
  output logic   rxEnable,
  output logic   frmReady,
  output logic   memReq,
  output logic   memWe,
  output dpCtl_t ctl
);
  typedef enum logic [2:0] {S_IDLE, S_RDSTAT, S_RDBUF, S_WAIT, S_COLLECT, S_WRSTAT} state_e;
  state_e state, nxt;
  logic stopNow;

  always_comb begin
    nxt      = state;
    ctl      = '0;
    ctl.sel  = SEL_STAT;
    frmReady = 1'b0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    stopNow  = 1'b0;
    case (state)
      S_IDLE: begin
        if (rxEnable) nxt = S_RDSTAT;
        else begin
          frmReady = 1'b1;
          ctl.dropFrame = frmValid && frmStart;
        end
      end
      S_RDSTAT: begin
        memReq = 1'b1;
        if (memAck) begin
          if (descOwned) begin
            ctl.capStat = 1'b1;
            nxt = S_RDBUF;
          end else begin
            stopNow = 1'b1;
            nxt = S_IDLE;
          end
        end
      end
      S_RDBUF: begin
        memReq  = 1'b1;
        ctl.sel = SEL_BUFP;
        if (memAck) begin
          ctl.capBuf = 1'b1;
          nxt = S_WAIT;
        end
      end
      S_WAIT: begin
        frmReady = 1'b1;
        if (frmValid && frmStart) begin
          ctl.takeByte = 1'b1;
          ctl.newFrame = 1'b1;
          nxt = S_COLLECT;
        end
      end
      S_COLLECT: begin
        ctl.sel = SEL_DATA;
        if (packFull || (endSeen && havePartial)) begin
          memReq = 1'b1;
          memWe  = 1'b1;
          ctl.flushWord = memAck;
        end else if (endSeen) begin
          nxt = S_WRSTAT;
        end else begin
          frmReady = 1'b1;
          ctl.takeByte = frmValid;
        end
      end
      S_WRSTAT: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          ctl.finishDesc = 1'b1;
          nxt = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      rxEnable <= 1'b0;
    end else begin
      state <= nxt;
      if (stopNow) rxEnable <= 1'b0;
      else if (rxEnSet) rxEnable <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_ring_dp.sv
module rx_ring_dp
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int MAX_BUF = 1540
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgPtrWe,
  input  logic [ADDR_W-1:0] cfgPtr,
  input  dpCtl_t            ctl,
  input  logic [7:0]        frmData,
  input  logic              frmEnd,
  input  logic              frmAlignErr,
  input  logic              frmCrcBad,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memBe,
  output logic              packFull,
  output logic              havePartial,
  output logic              endSeen
);
  localparam int LEN_W = $clog2(MAX_BUF + 1);

  logic [ADDR_W-1:0] basePtr, curPtr, bufAddr, wordAddr;
  logic [31:0]       packWord, statWord;
  logic [3:0]        packBe, beBase;
  logic [1:0]        lane, laneBase;
  logic [LEN_W-1:0]  byteCnt, cntBase;
  logic              wrapBit, crcF, alnF, longF, ovrF;

  assign cntBase  = ctl.newFrame ? '0 : byteCnt;
  assign laneBase = ctl.newFrame ? 2'd0 : lane;
  assign beBase   = ctl.newFrame ? 4'd0 : packBe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      basePtr <= '0; curPtr <= '0; bufAddr <= '0; wordAddr <= '0;
      packWord <= '0; packBe <= '0; lane <= '0; byteCnt <= '0;
      wrapBit <= 1'b0; crcF <= 1'b0; alnF <= 1'b0; longF <= 1'b0;
      ovrF <= 1'b0; endSeen <= 1'b0;
    end else begin
      if (cfgPtrWe) begin
        basePtr <= cfgPtr;
        curPtr  <= cfgPtr;
      end
      if (ctl.capStat) wrapBit <= memRdata[WRAP_BIT];
      if (ctl.capBuf)  bufAddr <= memRdata[ADDR_W-1:0];
      if (ctl.takeByte) begin
        if (ctl.newFrame) wordAddr <= bufAddr;
        if (cntBase < LEN_W'(MAX_BUF)) begin
          packWord[{laneBase, 3'b000} +: 8] <= frmData;
          packBe  <= beBase | (4'b0001 << laneBase);
          lane    <= laneBase + 2'd1;
          byteCnt <= cntBase + 1'b1;
          if (ctl.newFrame) longF <= 1'b0;
        end else begin
          longF <= 1'b1;
        end
        endSeen <= frmEnd;
        if (frmEnd) begin
          crcF <= frmCrcBad;
          alnF <= frmAlignErr;
        end else if (ctl.newFrame) begin
          crcF <= 1'b0;
          alnF <= 1'b0;
        end
      end
      if (ctl.flushWord) begin
        packBe   <= '0;
        wordAddr <= wordAddr + ADDR_W'(4);
      end
      if (ctl.finishDesc) begin
        curPtr <= wrapBit ? basePtr : curPtr + ADDR_W'(8);
        ovrF   <= 1'b0;
      end else if (ctl.dropFrame) begin
        ovrF <= 1'b1;
      end
    end
  end

  always_comb begin
    statWord = '0;
    statWord[LEN_W-1:0] = byteCnt;
    statWord[WRAP_BIT]  = wrapBit;
    statWord[ALN_BIT]   = alnF;
    statWord[LONG_BIT]  = longF;
    statWord[CRC_BIT]   = crcF;
    statWord[OVR_BIT]   = ovrF;
  end

  always_comb begin
    case (ctl.sel)
      SEL_BUFP: begin memAddr = curPtr + ADDR_W'(4); memWdata = statWord; memBe = 4'hF; end
      SEL_DATA: begin memAddr = wordAddr;            memWdata = packWord; memBe = packBe; end
      default:  begin memAddr = curPtr;              memWdata = statWord; memBe = 4'hF; end
    endcase
  end

  assign packFull    = (packBe == 4'hF);
  assign havePartial = |packBe;
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int MAX_BUF = 1540
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgPtrWe,
  input  logic [ADDR_W-1:0] cfgPtr,
  input  logic              rxEnSet,
  output logic              rxEnable,
  input  logic              frmValid,
  output logic              frmReady,
  input  logic [7:0]        frmData,
  input  logic              frmStart,
  input  logic              frmEnd,
  input  logic              frmAlignErr,
  input  logic              frmCrcBad,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memBe,
  input  logic [31:0]       memRdata,
  input  logic              memAck
);
  dpCtl_t ctl;
  logic   packFull, havePartial, endSeen;

  rx_ring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnSet(rxEnSet), .frmValid(frmValid),
    .frmStart(frmStart), .memAck(memAck), .descOwned(memRdata[EN_BIT]),
    .packFull(packFull), .havePartial(havePartial), .endSeen(endSeen),
    .rxEnable(rxEnable), .frmReady(frmReady), .memReq(memReq),
    .memWe(memWe), .ctl(ctl)
  );

  rx_ring_dp #(.ADDR_W(ADDR_W), .MAX_BUF(MAX_BUF)) u_dp (
    .clk(clk), .rstN(rstN), .cfgPtrWe(cfgPtrWe), .cfgPtr(cfgPtr), .ctl(ctl),
    .frmData(frmData), .frmEnd(frmEnd), .frmAlignErr(frmAlignErr),
    .frmCrcBad(frmCrcBad), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .memBe(memBe), .packFull(packFull),
    .havePartial(havePartial), .endSeen(endSeen)
  );
endmodule

// File: rtl/rx_ring_chk.sv
module rx_ring_chk #(
  parameter int ADDR_W  = 32,
  parameter int MAX_BUF = 1540
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              frmReady,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [3:0]        memBe,
  input logic              memRdEn,
  input logic [10:0]       wrLen,
  input logic              wrEn,
  input logic              selStat
);
  assert_hold_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  assert_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxEnable) |-> $past(memAck && !memWe && !memRdEn));

  assert_be_contig_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> (memBe == 4'h1 || memBe == 4'h3 || memBe == 4'h7 || memBe == 4'hF));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && selStat |-> !wrEn);

  assert_len_cap_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && selStat |-> wrLen <= 11'(MAX_BUF));

  assert_quiet_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |-> !memReq);

  assert_no_byte_mem_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(frmReady && memReq));
endmodule

bind rx_ring_dma rx_ring_chk #(.ADDR_W(ADDR_W), .MAX_BUF(MAX_BUF)) u_chk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .frmReady(frmReady),
  .memReq(memReq), .memWe(memWe), .memAck(memAck), .memAddr(memAddr),
  .memBe(memBe), .memRdEn(memRdata[rx_ring_pkg::EN_BIT]),
  .wrLen(memWdata[10:0]), .wrEn(memWdata[rx_ring_pkg::EN_BIT]),
  .selStat(ctl.sel == rx_ring_pkg::SEL_STAT)
);

// File: tb/test_rx_ring_dma.sv
`timescale 1ns/1ps
module test_rx_ring_dma;
  localparam int ADDR_W = 32;
  localparam int MAXB   = 1540;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgPtrWe = 1'b0, rxEnSet = 1'b0;
  logic [ADDR_W-1:0] cfgPtr = '0;
  logic rxEnable, frmReady, memReq, memWe, memAck;
  logic frmValid = 1'b0, frmStart = 1'b0, frmEnd = 1'b0, frmAlignErr = 1'b0, frmCrcBad = 1'b0;
  logic [7:0] frmData = '0;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0] memWdata, memRdata;
  logic [3:0] memBe;

  logic [31:0] mem [0:2047];
  logic [ADDR_W-1:0] readLog [0:63];
  int readCnt = 0, writeCnt = 0;
  logic hostWe = 1'b0;
  logic [10:0] hostIdx = '0;
  logic [31:0] hostData = '0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  rx_ring_dma #(.ADDR_W(ADDR_W), .MAX_BUF(MAXB)) i_rx_ring_dma (
    .clk(clk), .rstN(rstN), .cfgPtrWe(cfgPtrWe), .cfgPtr(cfgPtr), .rxEnSet(rxEnSet),
    .rxEnable(rxEnable), .frmValid(frmValid), .frmReady(frmReady), .frmData(frmData),
    .frmStart(frmStart), .frmEnd(frmEnd), .frmAlignErr(frmAlignErr), .frmCrcBad(frmCrcBad),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe),
    .memRdata(memRdata), .memAck(memAck)
  );

  function automatic logic [31:0] orig(int idx);
    return 32'hA5A5_0000 | 32'(idx);
  endfunction
  function automatic logic [7:0] pat(int seed, int i);
    return 8'((seed + i * 7) & 8'hFF);
  endfunction

  assign memRdata = mem[memAddr[12:2]];

  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0;
      for (int i = 0; i < 2048; i++) mem[i] <= orig(i);
    end else begin
      memAck <= memReq && !memAck;
      if (memReq && memAck) begin
        if (memWe) begin
          for (int b = 0; b < 4; b++)
            if (memBe[b]) mem[memAddr[12:2]][b*8 +: 8] <= memWdata[b*8 +: 8];
          writeCnt <= writeCnt + 1;
        end else begin
          if (readCnt < 64) readLog[readCnt] <= memAddr;
          readCnt <= readCnt + 1;
        end
      end
      if (hostWe) mem[hostIdx] <= hostData;
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(int addr, logic [31:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostIdx = 11'(addr >> 2); hostData = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic pulseEn();
    @(negedge clk); rxEnSet = 1'b1;
    @(negedge clk); rxEnSet = 1'b0;
  endtask

  task automatic sendFrame(int n, int seed, bit crc, bit aln, bit withStart);
    for (int i = 0; i < n; i++) begin
      bit acc;
      @(negedge clk);
      frmValid = 1'b1; frmData = pat(seed, i);
      frmStart = withStart && (i == 0); frmEnd = (i == n - 1);
      frmCrcBad = crc && (i == n - 1); frmAlignErr = aln && (i == n - 1);
      forever begin
        acc = frmReady;
        @(posedge clk);
        if (acc) break;
        @(negedge clk);
      end
    end
    @(negedge clk);
    frmValid = 1'b0; frmStart = 1'b0; frmEnd = 1'b0; frmCrcBad = 1'b0; frmAlignErr = 1'b0;
  endtask

  task automatic waitDone(int addr);
    for (int t = 0; t < 20000; t++) begin
      @(negedge clk);
      if (!mem[addr >> 2][11]) break;
    end
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [31:0] bufWord(int idx, int k, int n, int seed);
    logic [31:0] w = orig(idx);
    for (int j = 0; j < 4; j++)
      if (4 * k + j < n) w[j*8 +: 8] = pat(seed, 4 * k + j);
    return w;
  endfunction

  task automatic testReset();
    check(rxEnable == 1'b0, "R1 rxEnable after reset", 32'(rxEnable), 0);
    check(memReq == 1'b0, "R1 memReq after reset", 32'(memReq), 0);
  endtask

  task automatic testFirstFrame();
    hostWrite(32'h100, 32'h0000_0800); hostWrite(32'h104, 32'h800);
    hostWrite(32'h100, 32'h800);
    hostWrite(32'h108, 32'h800); hostWrite(32'h10C, 32'h1000);
    hostWrite(32'h110, 32'h1800); hostWrite(32'h114, 32'h1800);
    @(negedge clk); cfgPtrWe = 1'b1; cfgPtr = 32'h100;
    @(negedge clk); cfgPtrWe = 1'b0;
    pulseEn();
    sendFrame(6, 17, 1'b0, 1'b0, 1'b1);
    waitDone(32'h100);
    check(readLog[0] == 32'h100, "R2 status fetch address", readLog[0], 32'h100);
    check(readLog[1] == 32'h104, "R2 buffer fetch address", readLog[1], 32'h104);
    check(mem[32'h200] == bufWord(32'h200, 0, 6, 17), "R4 full word", mem[32'h200], bufWord(32'h200, 0, 6, 17));
    check(mem[32'h201] == bufWord(32'h201, 1, 6, 17), "R4 partial word", mem[32'h201], bufWord(32'h201, 1, 6, 17));
    check(mem[32'h40] == 32'd6, "R5 status len 6", mem[32'h40], 32'd6);
  endtask

  task automatic testCrcFrame();
    sendFrame(9, 90, 1'b1, 1'b0, 1'b1);
    waitDone(32'h108);
    check(readLog[2] == 32'h108 && readLog[3] == 32'h10C, "R8 advance by 8", readLog[2], 32'h108);
    check(mem[32'h42] == (32'd9 | (32'd1 << 15)), "R6 crc flag", mem[32'h42], 32'd9 | (32'd1 << 15));
    check(mem[32'h402] == bufWord(32'h402, 2, 9, 90), "R4 one-byte tail", mem[32'h402], bufWord(32'h402, 2, 9, 90));
  endtask

  task automatic testWrapStop();
    logic [31:0] exp = 32'd4 | (32'd1 << 12) | (32'd1 << 13);
    sendFrame(4, 200, 1'b0, 1'b1, 1'b1);
    waitDone(32'h110);
    repeat (10) @(negedge clk);
    check(mem[32'h44] == exp, "R5 R6 wrap kept, align flag", mem[32'h44], exp);
    check(readLog[readCnt - 1] == 32'h100, "R8 wrap to base", readLog[readCnt - 1], 32'h100);
    check(rxEnable == 1'b0, "R3 stop on software-owned descriptor", 32'(rxEnable), 0);
  endtask

  task automatic testDrop();
    int wc = writeCnt;
    sendFrame(5, 3, 1'b0, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    check(writeCnt == wc, "R9 no write while disabled", 32'(writeCnt), 32'(wc));
    check(memReq == 1'b0, "R3 no access after stop", 32'(memReq), 0);
  endtask

  task automatic testResume();
    int rc;
    hostWrite(32'h100, 32'h800);
    hostWrite(32'h108, 32'h800);
    rc = readCnt;
    pulseEn();
    sendFrame(3, 55, 1'b0, 1'b0, 1'b0);
    sendFrame(3, 120, 1'b0, 1'b0, 1'b1);
    waitDone(32'h100);
    check(readLog[rc] == 32'h100, "R10 resume at stopped descriptor", readLog[rc], 32'h100);
    check(mem[32'h40] == (32'd3 | (32'd1 << 16)), "R9 overrun flag", mem[32'h40], 32'd3 | (32'd1 << 16));
    check(mem[32'h200][23:0] == {pat(120, 2), pat(120, 1), pat(120, 0)}, "R11 garbage skipped",
          {8'h0, mem[32'h200][23:0]}, {8'h0, pat(120, 2), pat(120, 1), pat(120, 0)});
    check(mem[32'h200][31:24] == pat(17, 3), "R4 lane 3 untouched", {24'h0, mem[32'h200][31:24]}, {24'h0, pat(17, 3)});
  endtask

  task automatic testLong();
    logic [31:0] exp = 32'(MAXB) | (32'd1 << 14);
    sendFrame(MAXB + 5, 9, 1'b0, 1'b0, 1'b1);
    waitDone(32'h108);
    check(mem[32'h42] == exp, "R7 too-long status", mem[32'h42], exp);
    check(mem[(32'h1000 + MAXB) / 4 - 1] == bufWord((32'h1000 + MAXB) / 4 - 1, MAXB / 4 - 1, MAXB, 9),
          "R7 last stored word", mem[(32'h1000 + MAXB) / 4 - 1], bufWord((32'h1000 + MAXB) / 4 - 1, MAXB / 4 - 1, MAXB, 9));
    check(mem[(32'h1000 + MAXB) / 4] == orig((32'h1000 + MAXB) / 4), "R7 no write past buffer",
          mem[(32'h1000 + MAXB) / 4], orig((32'h1000 + MAXB) / 4));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFirstFrame();
    testCrcFrame();
    testWrapStop();
    testDrop();
    testResume();
    testLong();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule